// File: doc/BRIEF.md
# Microprogram Sequencer with Nested Calls and Loops

This block produces the microaddress that selects the next word of an external control store. Each cycle it acts on a decoded sequencer opcode, an 8-bit field that is either a branch target or a loop count, and a condition flag from the controlled datapath. It supports sequential stepping, unconditional and conditional jumps, nested subroutine call and return, and nested counted loops. It keeps two small last-in-first-out stacks: one holds return addresses and one holds loop entries, each entry being a count and a start address.

Two modes are chosen at reset. In the nonpipelined mode the word read at the current microaddress is executed in the same cycle, so every change of flow is seen at the very next microaddress. In the pipelined mode the fetched word is captured in an instruction register and executed one cycle later. While it executes, the word after it is already being fetched, and that word always runs as a delay slot before any change of flow takes effect. An illegal stack operation sets a sticky error flag.

Top module: `microseq`

## Requirements
- R1: A synchronous reset drives `uaddr` to 0, clears `err` and empties both stacks, so a return or loop end executed right after reset finds an empty stack.
- R2: The step opcode (code 0) advances `uaddr` by one, and from 255 it wraps to 0.
- R3: Opcode 1 jumps to `field_in`. Opcode 2 jumps to `field_in` when `cond` is 1 and steps when `cond` is 0.
- R4: Opcode 3 (call) pushes the link address (current `uaddr` plus one) and jumps to `field_in`. Opcode 4 (return) jumps to the most recently pushed link and removes it. Calls nest four deep.
- R5: Opcode 5 pushes a loop entry holding the count `field_in` and the start address (current `uaddr` plus one). Opcode 6 (loop end) decrements the top count and branches to its start when the count is greater than 1; otherwise it removes the entry and steps. Loops nest four deep, and an inner loop completes within each outer pass.
- R6: With `pipe_mode` 0 during reset, the word presented at `uaddr` executes in the same cycle, and any jump, call, return or loop branch appears on the next `uaddr`.
- R7: With `pipe_mode` 1 during reset, the word presented at `uaddr` executes one cycle later. The word fetched just after a flow-changing word always executes before the new flow. The instruction register holds a step after reset.
- R8: A push onto a full stack, or a return or loop end on an empty stack, sets `err`. `err` stays set until reset. The stack contents are left unchanged, and flow continues with `uaddr` plus one.
- R9: `pipe_mode` is sampled only while `rst` is 1. Changes after reset have no effect on the address sequence.
- R10: Opcode 7 is reserved and behaves as a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pipe_mode | input | 1 | 1 selects pipelined mode; sampled during reset only |
| op_in | input | 3 | Opcode of the control-store word at `uaddr` |
| field_in | input | 8 | Branch target or loop count of that word |
| cond | input | 1 | Condition flag for the conditional jump |
| uaddr | output | 8 | Microaddress presented to the control store |
| err | output | 1 | Sticky stack error flag |

## Verification
The hardest situation to reach from the ports is a full return stack being pushed once more and then unwound. It only shows that the contents are untouched if every stored link is distinct. The bench runs a chain of calls from different addresses until the fifth one overflows, then returns through every level and one step beyond. The address trace shows both the unchanged stack and the empty-stack error. A second hard case is the pipelined delay slot around loop back-branches and returns. It is reached with a control-store program whose slot words are laid out so that the exact fetch sequence is fixed.

// File: rtl/microseq_pkg.sv
package microseq_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_STEP   = 3'd0,
    OP_JUMP   = 3'd1,
    OP_JUMPIF = 3'd2,
    OP_CALL   = 3'd3,
    OP_RET    = 3'd4,
    OP_LPUSH  = 3'd5,
    OP_LEND   = 3'd6,
    OP_RSVD   = 3'd7
  } useq_op_e;
endpackage

// File: rtl/useq_lifo.sv
module useq_lifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic         wr_top,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         empty,
  output logic         full,
  output logic         fault
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IW    = $clog2(DEPTH);

  logic [CNT_W-1:0] cnt;
  logic [W-1:0]     mem [DEPTH];
  logic [IW-1:0]    wr_idx;
  logic [IW-1:0]    top_idx;
  logic             ovf_evt;
  logic             unf_evt;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CNT_W'(DEPTH));
  assign wr_idx  = IW'(cnt);
  assign top_idx = IW'(cnt - CNT_W'(1));
  assign top     = mem[top_idx];

  // illegal requests are named events so the parent and assertions see them
  assign ovf_evt = push && full;
  assign unf_evt = (pop || wr_top) && empty;
  assign fault   = ovf_evt || unf_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (push && !full) begin
      cnt <= cnt + CNT_W'(1);
    end else if (pop && !empty) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst) begin
      if (push && !full) begin
        mem[wr_idx] <= din;
      end else if (wr_top && !empty) begin
        mem[top_idx] <= din;
      end
    end
  end

  // R4
  push_top_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !full) |=> (!empty && top == $past(din)));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> (full && top == $past(top)));

  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    unf_evt |=> empty);
endmodule

// File: rtl/useq_nextaddr.sv
module useq_nextaddr
  import microseq_pkg::*;
#(
  parameter int AW = 8,
  parameter int CW = 8
) (
  input  useq_op_e          op,
  input  logic [AW-1:0]     field,
  input  logic              cond,
  input  logic [AW-1:0]     pc,
  input  logic [AW-1:0]     ret_top,
  input  logic              ret_empty,
  input  logic              ret_full,
  input  logic [CW-1:0]     lp_cnt,
  input  logic [AW-1:0]     lp_start,
  input  logic              lp_empty,
  output logic [AW-1:0]     nxt,
  output logic              ret_push,
  output logic              ret_pop,
  output logic [AW-1:0]     ret_din,
  output logic              lp_push,
  output logic              lp_pop,
  output logic              lp_wr,
  output logic [CW-1:0]     lp_din_cnt,
  output logic [AW-1:0]     lp_din_start
);
  function automatic logic [AW-1:0] addr_inc(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  function automatic logic loop_again(input logic [CW-1:0] c);
    return c > CW'(1);
  endfunction

  function automatic logic [CW-1:0] cnt_dec(input logic [CW-1:0] c);
    return c - CW'(1);
  endfunction

  logic [AW-1:0] link;
  assign link = addr_inc(pc);

  always_comb begin
    nxt          = link;
    ret_push     = 1'b0;
    ret_pop      = 1'b0;
    ret_din      = link;
    lp_push      = 1'b0;
    lp_pop       = 1'b0;
    lp_wr        = 1'b0;
    lp_din_cnt   = field[CW-1:0];
    lp_din_start = link;
    case (op)
      OP_JUMP:   nxt = field;
      OP_JUMPIF: if (cond) nxt = field;
      OP_CALL: begin
        ret_push = 1'b1;
        if (!ret_full) nxt = field;
      end
      OP_RET: begin
        ret_pop = 1'b1;
        if (!ret_empty) nxt = ret_top;
      end
      OP_LPUSH:  lp_push = 1'b1;
      OP_LEND: begin
        if (!lp_empty && loop_again(lp_cnt)) begin
          lp_wr        = 1'b1;
          lp_din_cnt   = cnt_dec(lp_cnt);
          lp_din_start = lp_start;
          nxt          = lp_start;
        end else begin
          lp_pop = 1'b1;
        end
      end
      default: nxt = link;
    endcase
  end
endmodule

// File: rtl/microseq.sv
module microseq
  import microseq_pkg::*;
#(
  parameter int AW         = 8,
  parameter int CW         = 8,
  parameter int RET_DEPTH  = 4,
  parameter int LOOP_DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pipe_mode,
  input  logic [OP_W-1:0] op_in,
  input  logic [AW-1:0]   field_in,
  input  logic            cond,
  output logic [AW-1:0]   uaddr,
  output logic            err
);
  localparam int LW = CW + AW;

  logic          pipe_q;
  useq_op_e      mir_op;
  logic [AW-1:0] mir_field;
  useq_op_e      exec_op;
  logic [AW-1:0] exec_field;
  logic [AW-1:0] nxt;

  logic          ret_push, ret_pop, ret_empty, ret_full, ret_fault;
  logic [AW-1:0] ret_din, ret_top;
  logic          lp_push, lp_pop, lp_wr, lp_empty, lp_full, lp_fault;
  logic [CW-1:0] lp_din_cnt, lp_cnt;
  logic [AW-1:0] lp_din_start, lp_start;
  logic [LW-1:0] lp_top;

  // mode is captured only under reset
  always_ff @(posedge clk) begin
    if (rst) pipe_q <= pipe_mode;
  end

  // instruction register for the pipelined mode
  always_ff @(posedge clk) begin
    if (rst) begin
      mir_op    <= OP_STEP;
      mir_field <= '0;
    end else begin
      mir_op    <= useq_op_e'(op_in);
      mir_field <= field_in;
    end
  end

  assign exec_op    = pipe_q ? mir_op : useq_op_e'(op_in);
  assign exec_field = pipe_q ? mir_field : field_in;

  useq_nextaddr #(.AW(AW), .CW(CW)) u_next (
    .op(exec_op), .field(exec_field), .cond(cond), .pc(uaddr),
    .ret_top(ret_top), .ret_empty(ret_empty), .ret_full(ret_full),
    .lp_cnt(lp_cnt), .lp_start(lp_start), .lp_empty(lp_empty),
    .nxt(nxt), .ret_push(ret_push), .ret_pop(ret_pop), .ret_din(ret_din),
    .lp_push(lp_push), .lp_pop(lp_pop), .lp_wr(lp_wr),
    .lp_din_cnt(lp_din_cnt), .lp_din_start(lp_din_start)
  );

  useq_lifo #(.W(AW), .DEPTH(RET_DEPTH)) u_ret_stack (
    .clk(clk), .rst(rst), .push(ret_push), .pop(ret_pop), .wr_top(1'b0),
    .din(ret_din), .top(ret_top), .empty(ret_empty), .full(ret_full),
    .fault(ret_fault)
  );

  useq_lifo #(.W(LW), .DEPTH(LOOP_DEPTH)) u_loop_stack (
    .clk(clk), .rst(rst), .push(lp_push), .pop(lp_pop), .wr_top(lp_wr),
    .din({lp_din_cnt, lp_din_start}), .top(lp_top), .empty(lp_empty),
    .full(lp_full), .fault(lp_fault)
  );

  assign lp_cnt   = lp_top[LW-1:AW];
  assign lp_start = lp_top[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      uaddr <= '0;
      err   <= 1'b0;
    end else begin
      uaddr <= nxt;
      if (ret_fault || lp_fault) err <= 1'b1;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (uaddr == '0 && !err));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  // R2
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (exec_op == OP_STEP) |=> (uaddr == $past(uaddr) + AW'(1)));

  // R3
  jump_chk: assert property (@(posedge clk) disable iff (rst)
    (exec_op == OP_JUMP) |=> (uaddr == $past(exec_field)));

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(pipe_q));

  // R8
  full_call_chk: assert property (@(posedge clk) disable iff (rst)
    (exec_op == OP_CALL && lp_full == lp_full && ret_full) |=> (err && uaddr == $past(uaddr) + AW'(1)));
endmodule

// File: tb/microseq_test.sv
`timescale 1ns/1ps
module microseq_test;
  localparam logic [2:0] S = 3'd0, J = 3'd1, JI = 3'd2, C = 3'd3,
                         RT = 3'd4, LP = 3'd5, LE = 3'd6, RSV = 3'd7;
  localparam int NVEC = 63;
  // {run, expected uaddr}: run 0 nonpipelined cond=1, run 1 nonpipelined cond=0, run 2 pipelined
  localparam logic [9:0] VEC [NVEC] = '{
    10'h000, 10'h00A, 10'h00B, 10'h001, 10'h002, 10'h003, 10'h004, 10'h003,
    10'h004, 10'h003, 10'h004, 10'h005, 10'h002, 10'h003, 10'h004, 10'h003,
    10'h004, 10'h003, 10'h004, 10'h005, 10'h006, 10'h009, 10'h009,
    10'h100, 10'h10A, 10'h10B, 10'h101, 10'h102, 10'h103, 10'h104, 10'h103,
    10'h104, 10'h103, 10'h104, 10'h105, 10'h102, 10'h103, 10'h104, 10'h103,
    10'h104, 10'h103, 10'h104, 10'h105, 10'h106, 10'h107, 10'h108,
    10'h200, 10'h201, 10'h20C, 10'h20D, 10'h20E, 10'h202, 10'h203, 10'h204,
    10'h205, 10'h206, 10'h204, 10'h205, 10'h206, 10'h207, 10'h208, 10'h207,
    10'h208
  };
  localparam logic [7:0] OVF_TR [12] = '{8'd0, 8'd10, 8'd20, 8'd30, 8'd40, 8'd41,
                                         8'd31, 8'd21, 8'd11, 8'd1, 8'd2, 8'd2};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pipe_mode = 1'b0;
  logic [2:0] op_in;
  logic [7:0] field_in;
  logic       cond = 1'b0;
  logic [7:0] uaddr;
  logic       err;
  logic [10:0] store [256];
  int total = 0;
  int fails = 0;

  microseq uut (.clk(clk), .rst(rst), .pipe_mode(pipe_mode), .op_in(op_in),
                .field_in(field_in), .cond(cond), .uaddr(uaddr), .err(err));

  always #5 clk = ~clk;

  always_comb begin
    op_in    = store[uaddr][10:8];
    field_in = store[uaddr][7:0];
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_store();
    for (int a = 0; a < 256; a++) store[a] = 11'd0;
  endtask

  task automatic put(input int a, input logic [2:0] o, input int f);
    store[a] = {o, 8'(f)};
  endtask

  task automatic do_reset(input logic m);
    rst = 1'b1;
    pipe_mode = m;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load_np();
    clear_store();
    put(0, C, 10); put(1, LP, 2); put(2, LP, 3); put(3, RSV, 0);
    put(4, LE, 0); put(5, LE, 0); put(6, JI, 9); put(7, S, 0);
    put(8, J, 8); put(9, J, 9); put(10, S, 0); put(11, RT, 0);
  endtask

  task automatic load_pl();
    clear_store();
    put(0, C, 12); put(1, S, 0); put(2, LP, 2); put(3, S, 0);
    put(4, S, 0); put(5, LE, 0); put(6, S, 0); put(7, J, 7);
    put(8, S, 0); put(12, S, 0); put(13, RT, 0); put(14, S, 0);
  endtask

  initial begin
    #1_000_000;
    total++;
    fails++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [1:0] run;
    logic [1:0] prev_run;
    string tg;
    clear_store();
    @(negedge clk);
    do_reset(1'b0);
    chk("R1 reset uaddr", int'(uaddr), 0);
    chk("R1 reset err", int'(err), 0);

    // table walk: R2 R3 R4 R5 R6 R7 R9 R10
    prev_run = 2'd3;
    for (int i = 0; i < NVEC; i++) begin
      run = VEC[i][9:8];
      if (run != prev_run) begin
        if (run == 2'd2) load_pl(); else load_np();
        cond = (run == 2'd0);
        do_reset(run == 2'd2);
        if (run != 2'd2) pipe_mode = 1'b1;   // R9: ignored after reset
        prev_run = run;
      end
      tg = (run == 2'd0) ? "R2 R3 R4 R5 R6 R9 R10 trace" :
           (run == 2'd1) ? "R3 R6 trace cond0" : "R4 R5 R7 pipelined trace";
      chk(tg, int'(uaddr), int'(VEC[i][7:0]));
      step();
    end

    // R8 return stack overflow and underflow with distinct links
    clear_store();
    put(0, C, 10); put(10, C, 20); put(20, C, 30); put(30, C, 40); put(40, C, 50);
    put(41, RT, 0); put(31, RT, 0); put(21, RT, 0); put(11, RT, 0);
    put(1, RT, 0); put(2, J, 2);
    do_reset(1'b0);
    for (int i = 0; i < 12; i++) begin
      chk("R8 R4 overflow trace", int'(uaddr), int'(OVF_TR[i]));
      if (i == 4) chk("R8 err before overflow", int'(err), 0);
      if (i == 5) chk("R8 err after overflow", int'(err), 1);
      if (i == 11) chk("R8 err sticky", int'(err), 1);
      step();
    end

    // R1 reset clears err and a nonempty return stack
    put(2, C, 20); put(20, J, 20);
    step();
    chk("R4 call from 2", int'(uaddr), 20);
    clear_store();
    put(0, J, 5); put(5, RT, 0); put(6, J, 6);
    do_reset(1'b0);
    chk("R1 reset uaddr after run", int'(uaddr), 0);
    chk("R1 reset clears err", int'(err), 0);
    step();
    chk("R1 jump to 5", int'(uaddr), 5);
    step();
    chk("R1 stack emptied: return falls through", int'(uaddr), 6);
    chk("R8 return on empty sets err", int'(err), 1);

    // R8 loop end on empty loop stack
    clear_store();
    put(0, LE, 0); put(1, J, 1);
    do_reset(1'b0);
    step();
    chk("R8 loop end empty uaddr", int'(uaddr), 1);
    chk("R8 loop end empty err", int'(err), 1);

    // R2 wrap from 255
    clear_store();
    put(0, J, 254);
    do_reset(1'b0);
    step();
    chk("R2 jump 254", int'(uaddr), 254);
    step();
    chk("R2 step 255", int'(uaddr), 255);
    step();
    chk("R2 wrap to 0", int'(uaddr), 0);

    // R7 R3 pipelined conditional jump, taken and not taken
    clear_store();
    put(0, JI, 8); put(1, S, 0); put(8, J, 8);
    cond = 1'b1;
    do_reset(1'b1);
    chk("R7 fetch 0", int'(uaddr), 0);
    step(); chk("R7 delay slot fetch", int'(uaddr), 1);
    step(); chk("R3 R7 taken target", int'(uaddr), 8);
    step(); chk("R7 slot after target", int'(uaddr), 9);
    step(); chk("R7 jump to 8 after slot", int'(uaddr), 8);
    cond = 1'b0;
    do_reset(1'b1);
    step(); step();
    chk("R3 R7 not taken", int'(uaddr), 2);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule